// File: doc/BRIEF.md
# Character Video Address Generator

This block produces the screen-memory address and the glyph row number for a text display with a fixed number of characters per line. A base register holds the memory position of the first character of the current character row. At the start of each raster line the running address counter is reloaded from that base. The counter then steps once per character slot, and it keeps stepping after the visible part of the line has ended.

The address is split into two parts. The upper bits form a reloadable counter, and this is the only part that the base register saves. The two low bits form a small separate counter, which is cleared at every line start. A 3-bit glyph row counter advances once per raster line. When the eighth raster line of a character row ends, the base register takes the upper bits of the address that follows the last visible character. With 40 characters per line, consecutive character rows start at addresses 0, 40, 80 and so on. A frame-start pulse brings everything back to address 0 and glyph row 0.

Top module: `txtv_addr_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, `mem_addr` becomes 0, `row_idx` becomes 0 and the saved row base becomes 0, whatever the value of `slot_en`.
- R2: A rising clock edge with `slot_en` low changes no state. `mem_addr`, `row_idx` and the saved row base all hold, whatever `disp_act` and `frame_start` do.
- R3: A line start is an enabled slot in which `disp_act` is high and was low in the previous enabled slot. At a line start the upper 8 bits of `mem_addr` (bits 9:2) are loaded from the saved row base, and the low 2 bits (bits 1:0) are cleared to 0.
- R4: Every other enabled slot without a frame start increments `mem_addr` by 1, modulo 1024. This also applies while `disp_act` is low after the visible part of the line.
- R5: The low bits are cleared only in the line-start slot. The 40 active slots of a line therefore show base*4+0 through base*4+39 in order, with no address repeated.
- R6: `row_idx` changes only at a line end (an enabled slot in which `disp_act` is low and was high in the previous enabled slot) or at a frame start. A line end increments it, and it wraps from 7 to 0.
- R7: At a line end while `row_idx` is 7, the saved row base takes bits 9:2 of the address after that slot's increment. At no other time does the base change, so all 8 raster lines of a character row begin at the same address.
- R8: With 40 active slots per line, consecutive character rows begin at addresses 0, 40, 80, 120, 160, 200, 240.
- R9: An enabled slot with `frame_start` high clears `mem_addr`, `row_idx` and the saved row base to 0. It takes priority over line start, line end and increment, and it arms a new line start for the next slot in which `disp_act` is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slot_en | input | 1 | Character-slot enable; gates every state change |
| disp_act | input | 1 | Display-active level; high during the visible characters of a raster line |
| frame_start | input | 1 | Frame-start pulse, sampled in enabled slots |
| mem_addr | output | 10 | Screen-memory address, {upper counter, low counter} |
| row_idx | output | 3 | Glyph row number for the character ROM |

## Verification
A wrong low counter shows up at the second slot of any raster line, either as a repeated or a skipped address. A wrong base register stays hidden until the first line of the next character row. That line then starts at a wrong address, for example 36 instead of 40 if a stray clear ate three steps. For this reason every raster line of several whole character rows is compared slot by slot. A wrong glyph row count shows in `row_idx` at the next line end, and it also moves the base capture by a whole row, which puts every later row off by 40.

// File: rtl/txtv_pkg.sv
`timescale 1ns/1ps
package txtv_pkg;

    // Decoded meaning of one clock edge for the address state.
    typedef enum logic [2:0] {
        SLOT_NONE       = 3'd0,
        SLOT_STEP       = 3'd1,
        SLOT_LINE_START = 3'd2,
        SLOT_LINE_END   = 3'd3,
        SLOT_FRAME      = 3'd4
    } slot_ev_e;

    // Slots in which the address counter advances by one.
    function automatic logic ev_advances(slot_ev_e ev);
        return (ev == SLOT_STEP) || (ev == SLOT_LINE_END);
    endfunction

endpackage

// File: rtl/txtv_slot_event.sv
`timescale 1ns/1ps
module txtv_slot_event
    import txtv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     slot_en,
    input  logic     disp_act,
    input  logic     frame_start,
    output slot_ev_e ev_o
);

    typedef struct packed {
        logic act_prev;
    } ev_st_t;

    ev_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ev_o = SLOT_NONE;
        if (slot_en) begin
            if (frame_start) begin
                ev_o          = SLOT_FRAME;
                st_d.act_prev = 1'b0;
            end else begin
                st_d.act_prev = disp_act;
                if (disp_act && !st_q.act_prev) begin
                    ev_o = SLOT_LINE_START;
                end else if (!disp_act && st_q.act_prev) begin
                    ev_o = SLOT_LINE_END;
                end else begin
                    ev_o = SLOT_STEP;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/txtv_low_ctr.sv
`timescale 1ns/1ps
module txtv_low_ctr
    import txtv_pkg::*;
#(
    parameter int unsigned LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_ev_e         ev_i,
    output logic [LOW_W-1:0] low_o,
    output logic             carry_o
);

    localparam logic [LOW_W-1:0] LOW_MAX = '1;
    localparam logic [LOW_W-1:0] LOW_ONE = LOW_W'(1);

    typedef struct packed {
        logic [LOW_W-1:0] low;
    } low_st_t;

    low_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        carry_o = ev_advances(ev_i) && (st_q.low == LOW_MAX);
        case (ev_i)
            SLOT_FRAME,
            SLOT_LINE_START: st_d.low = '0;
            SLOT_STEP,
            SLOT_LINE_END:   st_d.low = st_q.low + LOW_ONE;
            default:         st_d.low = st_q.low;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_o = st_q.low;

endmodule

// File: rtl/txtv_upper_ctr.sv
`timescale 1ns/1ps
module txtv_upper_ctr
    import txtv_pkg::*;
#(
    parameter int unsigned UP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_ev_e        ev_i,
    input  logic            carry_i,
    input  logic            capture_i,
    output logic [UP_W-1:0] upper_o
);

    localparam logic [UP_W-1:0] UP_ONE = UP_W'(1);

    typedef struct packed {
        logic [UP_W-1:0] cnt;
        logic [UP_W-1:0] base;
    } up_st_t;

    up_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (ev_i)
            SLOT_FRAME: begin
                st_d.cnt  = '0;
                st_d.base = '0;
            end
            SLOT_LINE_START: st_d.cnt = st_q.base;
            SLOT_STEP,
            SLOT_LINE_END: begin
                if (carry_i) begin
                    st_d.cnt = st_q.cnt + UP_ONE;
                end
            end
            default: st_d.cnt = st_q.cnt;
        endcase
        // Next row base: upper bits of the address one past the line.
        if (capture_i) begin
            st_d.base = st_d.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upper_o = st_q.cnt;

endmodule

// File: rtl/txtv_glyph_row.sv
`timescale 1ns/1ps
module txtv_glyph_row
    import txtv_pkg::*;
#(
    parameter int unsigned ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_ev_e         ev_i,
    output logic [ROW_W-1:0] row_o,
    output logic             last_o
);

    localparam logic [ROW_W-1:0] ROW_LAST = '1;
    localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
    } row_st_t;

    row_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        last_o = (st_q.row == ROW_LAST);
        case (ev_i)
            SLOT_FRAME:    st_d.row = '0;
            SLOT_LINE_END: st_d.row = st_q.row + ROW_ONE;
            default:       st_d.row = st_q.row;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o = st_q.row;

endmodule

// File: rtl/txtv_addr_gen.sv
`timescale 1ns/1ps
module txtv_addr_gen
    import txtv_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LOW_W  = 2,
    parameter int unsigned ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_en,
    input  logic              disp_act,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ROW_W-1:0]  row_idx
);

    localparam int unsigned UP_W = ADDR_W - LOW_W;

    slot_ev_e         slot_ev;
    logic [LOW_W-1:0] low_bits;
    logic [UP_W-1:0]  up_bits;
    logic             low_carry;
    logic             row_last;
    logic             base_capture;

    txtv_slot_event u_event (
        .clk         (clk),
        .rst         (rst),
        .slot_en     (slot_en),
        .disp_act    (disp_act),
        .frame_start (frame_start),
        .ev_o        (slot_ev)
    );

    txtv_low_ctr #(.LOW_W(LOW_W)) u_low (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (slot_ev),
        .low_o   (low_bits),
        .carry_o (low_carry)
    );

    txtv_glyph_row #(.ROW_W(ROW_W)) u_row (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (slot_ev),
        .row_o  (row_idx),
        .last_o (row_last)
    );

    assign base_capture = (slot_ev == SLOT_LINE_END) && row_last;

    txtv_upper_ctr #(.UP_W(UP_W)) u_upper (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (slot_ev),
        .carry_i   (low_carry),
        .capture_i (base_capture),
        .upper_o   (up_bits)
    );

    assign mem_addr = {up_bits, low_bits};

endmodule

// File: rtl/txtv_addr_gen_chk.sv
`timescale 1ns/1ps
module txtv_addr_gen_chk
    import txtv_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LOW_W  = 2,
    parameter int unsigned ROW_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_en,
    input logic              frame_start,
    input slot_ev_e          ev,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ROW_W-1:0]  row_idx
);

    localparam logic [ROW_W-1:0] ROW_LAST = '1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (mem_addr == '0) && (row_idx == '0)); // R1

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> $stable(mem_addr) && $stable(row_idx)); // R2

    AST_LINE_START_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ev == SLOT_LINE_START) |=> (mem_addr[LOW_W-1:0] == '0)); // R3

    AST_STEP_INCREMENT: assert property (@(posedge clk) disable iff (rst)
        ev_advances(ev) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R4

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev != SLOT_LINE_END) && (ev != SLOT_FRAME) |=> $stable(row_idx)); // R6

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ev == SLOT_LINE_END) && (row_idx == ROW_LAST) |=> (row_idx == '0)); // R6

    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ev == SLOT_FRAME) |=> (mem_addr == '0) && (row_idx == '0)); // R9

    AST_FRAME_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        slot_en && frame_start |-> (ev == SLOT_FRAME)); // R9

endmodule

bind txtv_addr_gen txtv_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_en     (slot_en),
    .frame_start (frame_start),
    .ev          (slot_ev),
    .mem_addr    (mem_addr),
    .row_idx     (row_idx)
);

// File: tb/txtv_addr_gen_tb.sv
`timescale 1ns/1ps
module txtv_addr_gen_tb;

    localparam int VIS   = 40;
    localparam int BLANK = 8;
    localparam int NROWS = 6;
    // Expected first address of each character row (R8).
    localparam int ROW_BASE [NROWS] = '{0, 40, 80, 120, 160, 200};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_en = 1'b0;
    logic       disp_act = 1'b0;
    logic       frame_start = 1'b0;
    logic [9:0] mem_addr;
    logic [2:0] row_idx;

    int n_cmp = 0;
    int n_bad = 0;

    txtv_addr_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .slot_en     (slot_en),
        .disp_act    (disp_act),
        .frame_start (frame_start),
        .mem_addr    (mem_addr),
        .row_idx     (row_idx)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one clock period; inputs change and outputs are read at negedge.
    task automatic slot(input logic en, input logic act, input logic fs);
        slot_en     = en;
        disp_act    = act;
        frame_start = fs;
        @(posedge clk);
        @(negedge clk);
    endtask

    // One raster line: VIS active slots then BLANK idle ones.
    task automatic raster_line(input int base, input int r);
        for (int j = 0; j < VIS; j++) begin
            slot(1'b1, 1'b1, 1'b0);
            if (j == 0) chk("R3 line start address", int'(mem_addr), base);
            else        chk("R5 active address", int'(mem_addr), base + j);
            if (j == 0) chk("R7 glyph row during line", int'(row_idx), r);
        end
        slot(1'b1, 1'b0, 1'b0);
        chk("R4 step at line end", int'(mem_addr), base + VIS);
        chk("R6 row after line end", int'(row_idx), (r + 1) % 8);
        for (int k = 1; k < BLANK; k++) begin
            slot(1'b1, 1'b0, 1'b0);
        end
        chk("R4 counting in blank", int'(mem_addr), base + VIS + BLANK - 1);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset with slot_en low still clears.
        rst = 1'b1;
        slot(1'b0, 1'b0, 1'b0);
        slot(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        chk("R1 reset address", int'(mem_addr), 0);
        chk("R1 reset row", int'(row_idx), 0);

        // R9: frame start, then free counting while display is off (R4).
        slot(1'b1, 1'b0, 1'b1);
        chk("R9 frame start address", int'(mem_addr), 0);
        chk("R9 frame start row", int'(row_idx), 0);
        for (int k = 0; k < 3; k++) slot(1'b1, 1'b0, 1'b0);
        chk("R4 count before first line", int'(mem_addr), 3);

        // Table walk: every raster line of several character rows (R7, R8).
        for (int e = 0; e < NROWS; e++) begin
            for (int r = 0; r < 8; r++) begin
                raster_line(ROW_BASE[e], r);
            end
        end

        // R2: edges without slot enable change nothing.
        begin
            int held_addr;
            held_addr = int'(mem_addr);
            for (int k = 0; k < 5; k++) slot(1'b0, 1'b1, 1'b1);
            chk("R2 address held", int'(mem_addr), held_addr);
            chk("R2 row held", int'(row_idx), 0);
        end
        // Saved base survived the disabled edges: next row starts at 240 (R2, R8).
        raster_line(240, 0);

        // R9: frame start wins over a line start and clears the saved base.
        slot(1'b1, 1'b1, 1'b1);
        chk("R9 priority address", int'(mem_addr), 0);
        chk("R9 priority row", int'(row_idx), 0);
        slot(1'b1, 1'b0, 1'b0);
        chk("R4 step after frame", int'(mem_addr), 1);
        for (int r = 0; r < 8; r++) raster_line(0, r);
        raster_line(40, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule